// File: doc/BRIEF.md
# Path Parity Error Monitor

This block checks the path parity of a byte stream whose payload has already been descrambled. Each accepted byte carries three side flags. One marks the first byte of a frame. One says whether the byte belongs to the payload envelope. One says whether the byte is the received parity byte. The block folds every payload byte into an 8-lane even parity accumulator. When the next frame starts, it stores the finished value. It then checks that stored value against the parity byte that arrives in the frame that follows.

Mismatches are added to a running counter in one of two ways: the number of differing lanes, or one per errored frame. A configuration pin also chooses what the counter does at its top value: wrap or saturate. A performance-monitoring interval pulse moves the running count into a holding register and clears the counter in the same cycle. The holding register changes at no other time.

The input is a valid/ready stream. `s_ready` is held high, so the block never applies back-pressure. A byte is taken on every clock edge where `s_valid` is high. The side flags are only looked at on accepted bytes.

Top module: `path_parity_mon`

## Requirements
- R1: Lane i of the parity accumulator is the XOR of bit i of every accepted byte with `s_pay`=1 in the current frame. Bytes with `s_pay`=0, and cycles with `s_valid`=0, leave the accumulator unchanged.
- R2: A frame begins on an accepted byte with `s_sof`=1. At that point the accumulator value for the frame that just ended is stored. A parity-marked byte (`s_parmark`=1) is compared with the stored value of the previous frame. A marker on the start byte itself is compared with the frame that ends on that byte.
- R3: After reset, no comparison takes place until one complete frame has been accumulated, from one `s_sof` to the next.
- R4: Only the first parity-marked byte of a frame is compared. Later markers in the same frame are ignored.
- R5: With `cfg_blk_mode`=0, each comparison adds to the counter the number of bit positions where the received byte and the stored parity differ (0 to 8).
- R6: With `cfg_blk_mode`=1, each comparison adds 1 if any bit differs, and 0 otherwise.
- R7: On a cycle with `pm_tick`=1, `hold_count` takes the running count and the running count clears. At all other times `hold_count` keeps its value. After reset, `hold_count` is 0.
- R8: If an increment falls in the same cycle as `pm_tick`, `hold_count` takes the count from before that increment. The increment becomes the whole value of the freshly cleared counter.
- R9: With `cfg_saturate`=0, a sum past 2^CNT_W-1 wraps modulo 2^CNT_W.
- R10: With `cfg_saturate`=1, the counter stops at 2^CNT_W-1 and stays there until `pm_tick` clears it.
- R11: `s_ready` is 1 at all times. A comparison reaches the counter on the second clock edge after the marked byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Byte valid |
| s_ready | output | 1 | Always 1; no back-pressure |
| s_data | input | BIP_W (8) | Descrambled byte |
| s_sof | input | 1 | First byte of a frame |
| s_pay | input | 1 | Byte is part of the payload envelope |
| s_parmark | input | 1 | Byte is the received parity byte |
| cfg_blk_mode | input | 1 | 0 = count bits, 1 = count errored frames |
| cfg_saturate | input | 1 | 0 = wrap, 1 = saturate |
| pm_tick | input | 1 | Interval pulse: latch and clear |
| hold_count | output | CNT_W (16) | Count latched at the last interval pulse |

## Verification
The bench builds the block with CNT_W=8 and BIP_W=8. An all-lanes-wrong frame adds 8, so the counter's top value is reached within about 32 errored frames. Both the wrap and the saturate behaviour can then be checked in a few hundred cycles, without the tens of thousands a 16-bit counter would need. The 8-bit lane width keeps the per-comparison step range (0 to 8) the same as in the default build.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  typedef enum logic {
    CNT_BITS   = 1'b0,
    CNT_BLOCKS = 1'b1
  } cnt_mode_e;

  typedef enum logic {
    LIM_WRAP = 1'b0,
    LIM_HOLD = 1'b1
  } lim_mode_e;
endpackage

// File: rtl/ppm_frame_accum.sv
module ppm_frame_accum #(
  parameter int BIP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic [BIP_W-1:0] data,
  input  logic             sof,
  input  logic             pay,
  input  logic             parmark,
  output logic             cmp_go,
  output logic [BIP_W-1:0] cmp_ref,
  output logic [BIP_W-1:0] cmp_rx
);
  logic [BIP_W-1:0] acc_q;
  logic [BIP_W-1:0] prev_q;
  logic             started_q;
  logic             ok_q;
  logic [BIP_W-1:0] pay_bits;
  logic             ok_eff;

  // A start byte closes the running frame, so its reference is the live accumulator.
  assign pay_bits = pay ? data : '0;
  assign ok_eff   = sof ? started_q : ok_q;
  assign cmp_ref  = sof ? acc_q : prev_q;
  assign cmp_rx   = data;
  assign cmp_go   = beat && parmark && ok_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      prev_q    <= '0;
      started_q <= 1'b0;
      ok_q      <= 1'b0;
    end else if (beat) begin
      if (sof) begin
        prev_q    <= acc_q;
        acc_q     <= pay_bits;
        started_q <= 1'b1;
        ok_q      <= started_q && !parmark;
      end else begin
        acc_q <= acc_q ^ pay_bits;
        if (parmark) ok_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ppm_cmp.sv
module ppm_cmp
  import ppm_pkg::*;
#(
  parameter int BIP_W = 8,
  localparam int AMT_W = $clog2(BIP_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [BIP_W-1:0] ref_par,
  input  logic [BIP_W-1:0] rx_par,
  input  cnt_mode_e        mode,
  output logic             inc_vld,
  output logic [AMT_W-1:0] inc_amt
);
  logic [BIP_W-1:0] diff;
  logic [AMT_W-1:0] ones;
  logic [AMT_W-1:0] amt_d;

  for (genvar g = 0; g < BIP_W; g++) begin : g_lane
    assign diff[g] = ref_par[g] ^ rx_par[g];
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < BIP_W; i++) ones = ones + AMT_W'(diff[i]);
  end

  assign amt_d = (mode == CNT_BLOCKS) ? AMT_W'(|diff) : ones;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inc_vld <= 1'b0;
      inc_amt <= '0;
    end else begin
      inc_vld <= go;
      inc_amt <= go ? amt_d : '0;
    end
  end
endmodule

// File: rtl/ppm_err_cnt.sv
module ppm_err_cnt
  import ppm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int AMT_W = 4,
  localparam int SUM_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_vld,
  input  logic [AMT_W-1:0] inc_amt,
  input  logic             pm_tick,
  input  lim_mode_e        lim,
  output logic [CNT_W-1:0] run_cnt,
  output logic [CNT_W-1:0] hold_cnt
);
  logic [CNT_W-1:0] base;
  logic [SUM_W-1:0] sum;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    base = pm_tick ? '0 : run_cnt;
    sum  = {1'b0, base} + SUM_W'(inc_amt);
    if (!inc_vld)        nxt = base;
    else if (sum[CNT_W]) nxt = (lim == LIM_HOLD) ? '1 : sum[CNT_W-1:0];
    else                 nxt = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      hold_cnt <= '0;
    end else begin
      run_cnt <= nxt;
      if (pm_tick) hold_cnt <= run_cnt;
    end
  end
endmodule

// File: rtl/path_parity_mon.sv
module path_parity_mon
  import ppm_pkg::*;
#(
  parameter int BIP_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [BIP_W-1:0] s_data,
  input  logic             s_sof,
  input  logic             s_pay,
  input  logic             s_parmark,
  input  logic             cfg_blk_mode,
  input  logic             cfg_saturate,
  input  logic             pm_tick,
  output logic [CNT_W-1:0] hold_count
);
  localparam int AMT_W = $clog2(BIP_W + 1);

  logic             beat;
  logic             cmp_go;
  logic [BIP_W-1:0] cmp_ref;
  logic [BIP_W-1:0] cmp_rx;
  logic             inc_vld;
  logic [AMT_W-1:0] inc_amt;
  logic [CNT_W-1:0] run_cnt;
  cnt_mode_e        mode;
  lim_mode_e        lim;

  assign s_ready = 1'b1;
  assign beat    = s_valid && s_ready;
  assign mode    = cnt_mode_e'(cfg_blk_mode);
  assign lim     = lim_mode_e'(cfg_saturate);

  ppm_frame_accum #(.BIP_W(BIP_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .beat(beat), .data(s_data), .sof(s_sof),
    .pay(s_pay), .parmark(s_parmark), .cmp_go(cmp_go), .cmp_ref(cmp_ref),
    .cmp_rx(cmp_rx)
  );

  ppm_cmp #(.BIP_W(BIP_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .go(cmp_go), .ref_par(cmp_ref), .rx_par(cmp_rx),
    .mode(mode), .inc_vld(inc_vld), .inc_amt(inc_amt)
  );

  ppm_err_cnt #(.CNT_W(CNT_W), .AMT_W(AMT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc_vld(inc_vld), .inc_amt(inc_amt),
    .pm_tick(pm_tick), .lim(lim), .run_cnt(run_cnt), .hold_cnt(hold_count)
  );
endmodule

// File: rtl/ppm_checker.sv
module ppm_checker #(
  parameter int BIP_W = 8,
  parameter int CNT_W = 16,
  localparam int AMT_W = $clog2(BIP_W + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pm_tick,
  input logic             cfg_blk_mode,
  input logic             cfg_saturate,
  input logic             inc_vld,
  input logic [AMT_W-1:0] inc_amt,
  input logic [CNT_W-1:0] run_cnt,
  input logic [CNT_W-1:0] hold_count
);
  a_r7_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !pm_tick |=> $stable(hold_count));

  a_r7_latch: assert property (@(posedge clk) disable iff (!rst_n)
    pm_tick |=> hold_count == $past(run_cnt));

  a_r8_clear_then_inc: assert property (@(posedge clk) disable iff (!rst_n)
    pm_tick |=> run_cnt == ($past(inc_vld) ? CNT_W'($past(inc_amt)) : '0));

  a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    inc_vld |-> inc_amt <= AMT_W'(BIP_W));

  a_r6_block_unit: assert property (@(posedge clk) disable iff (!rst_n)
    inc_vld && $past(cfg_blk_mode) |-> inc_amt <= AMT_W'(1));

  a_r10_sat_stays: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_saturate && !pm_tick && run_cnt == {CNT_W{1'b1}} |=> run_cnt == {CNT_W{1'b1}});

  a_r10_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_saturate && !pm_tick |=> run_cnt >= $past(run_cnt));
endmodule

bind path_parity_mon ppm_checker #(.BIP_W(BIP_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pm_tick(pm_tick), .cfg_blk_mode(cfg_blk_mode),
  .cfg_saturate(cfg_saturate), .inc_vld(inc_vld), .inc_amt(inc_amt),
  .run_cnt(run_cnt), .hold_count(hold_count)
);

// File: tb/path_parity_mon_tb.sv
module path_parity_mon_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_BIP_W   = 8;
  localparam int TB_CNT_W   = 8;
  localparam int MAXV       = (1 << TB_CNT_W) - 1;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                s_valid = 1'b0;
  logic                s_ready;
  logic [TB_BIP_W-1:0] s_data = '0;
  logic                s_sof = 1'b0;
  logic                s_pay = 1'b0;
  logic                s_parmark = 1'b0;
  logic                cfg_blk_mode = 1'b0;
  logic                cfg_saturate = 1'b0;
  logic                pm_tick = 1'b0;
  logic [TB_CNT_W-1:0] hold_count;

  int total = 0;
  int bad = 0;
  int model = 0;
  int last_hold = 0;
  logic [TB_BIP_W-1:0] prev_bip = '0;
  bit prev_valid = 1'b0;
  int    exp_q[$];
  string tag_q[$];
  logic  pm_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  path_parity_mon #(.BIP_W(TB_BIP_W), .CNT_W(TB_CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sof(s_sof), .s_pay(s_pay), .s_parmark(s_parmark),
    .cfg_blk_mode(cfg_blk_mode), .cfg_saturate(cfg_saturate),
    .pm_tick(pm_tick), .hold_count(hold_count)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: hold_count is updated on the edge that samples pm_tick.
  always @(posedge clk) pm_q <= pm_tick;
  always @(negedge clk) begin
    if (pm_q) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected latch", int'(hold_count), -1);
      end else begin
        check(tag_q.pop_front(), int'(hold_count), exp_q.pop_front());
      end
      last_hold = int'(hold_count);
    end
  end

  task automatic push(input int v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  function automatic int add_cnt(input int c, input int a);
    int s;
    s = c + a;
    if (s > MAXV) s = cfg_saturate ? MAXV : (s & MAXV);
    return s;
  endfunction

  task automatic beat(input bit v, input bit sof, input bit pay, input bit mk,
                      input logic [TB_BIP_W-1:0] d, input bit pm);
    s_valid = v; s_sof = sof; s_pay = pay; s_parmark = mk; s_data = d; pm_tick = pm;
    @(negedge clk);
    s_valid = 1'b0; s_sof = 1'b0; s_parmark = 1'b0; pm_tick = 1'b0;
  endtask

  task automatic send_frame(input logic [TB_BIP_W-1:0] mask, input bit mark_on_sof,
                            input bit extra_mark, input bit pm_after, input string tag);
    logic [TB_BIP_W-1:0] expb, nb, d;
    int amt;
    expb = prev_bip ^ mask;
    amt  = cfg_blk_mode ? int'(mask != 0) : $countones(mask);
    if (!prev_valid) amt = 0;
    if (mark_on_sof) begin
      beat(1, 1, 0, 1, expb, 0);
    end else begin
      beat(1, 1, 0, 0, TB_BIP_W'($urandom), 0);
      beat(1, 0, 0, 1, expb, 0);
    end
    if (pm_after) begin
      push(model, tag);
      model = amt;
    end else begin
      model = add_cnt(model, amt);
    end
    nb = '0;
    for (int i = 0; i < 4; i++) begin
      d = TB_BIP_W'($urandom);
      beat(1, 0, 1, 0, d, pm_after && i == 0);
      nb = nb ^ d;
      beat(0, 0, 1, 0, TB_BIP_W'($urandom), 0);
    end
    if (extra_mark) beat(1, 0, 0, 1, ~expb, 0);
    prev_bip = nb;
    prev_valid = 1'b1;
  endtask

  task automatic pm_only(input string tag);
    repeat (3) beat(0, 0, 0, 0, '0, 0);
    push(model, tag);
    model = 0;
    beat(0, 0, 0, 0, '0, 1);
    beat(0, 0, 0, 0, '0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset hold", int'(hold_count), 0);
    check("R11 ready", int'(s_ready), 1);

    // Bit mode, wrap
    send_frame(8'hFF, 0, 0, 0, "R3 first frame");
    send_frame(8'h00, 0, 0, 0, "R1 clean");
    check("R7 hold steady", int'(hold_count), 0);
    send_frame(8'h13, 0, 0, 0, "R5 bits");
    send_frame(8'h00, 0, 1, 0, "R4 extra marker");
    send_frame(8'h01, 1, 0, 0, "R2 mark on sof");
    pm_only("R5 R4 R3 R2 R1 bit count");

    // Block mode
    cfg_blk_mode = 1'b1;
    send_frame(8'hF0, 0, 0, 0, "R6");
    send_frame(8'h01, 0, 0, 0, "R6");
    check("R7 hold steady after frames", int'(hold_count), last_hold);
    pm_only("R6 block count");

    // Simultaneous increment and interval pulse
    cfg_blk_mode = 1'b0;
    send_frame(8'h07, 0, 0, 1, "R8 latch before inc");
    pm_only("R8 inc in cleared counter");
    check("R11 ready", int'(s_ready), 1);

    // Wrap
    for (int k = 0; k < 32; k++) send_frame(8'hFF, 0, 0, 0, "R9");
    send_frame(8'h03, 0, 0, 0, "R9");
    check("R7 hold steady before wrap latch", int'(hold_count), last_hold);
    pm_only("R9 wrap");

    // Saturate
    cfg_saturate = 1'b1;
    for (int k = 0; k < 33; k++) send_frame(8'hFF, 0, 0, 0, "R10");
    pm_only("R10 saturate");
    pm_only("R7 cleared after latch");

    repeat (3) @(negedge clk);
    check("R7 scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule